// File: doc/BRIEF.md
# Programmable 16x Baud-Rate Tick Generator

This block turns the system clock into a clock-enable pulse that fires at sixteen times the serial bit rate. It counts system clock cycles against a 16-bit divisor, so the pulse rate is the clock frequency divided by the divisor. A receiver or transmitter that runs on the same clock uses the pulse as its oversampling strobe. The pulse is never used as a clock.

Software programs the divisor one byte at a time, through separate write strobes for the upper and lower byte. A write to either byte takes effect at once: the counter restarts from the new combined divisor, so there is no wait for the old period to end. A divisor of zero, which is also the reset value, stops the generator. A second output divides the pulse train by sixteen to give one pulse per bit time. It is gated by an enable, so an external monitor can measure the real bit rate.

Top module: `baudgen`

## Requirements
- R1: After reset both divisor bytes are zero, and neither `tick16_o` nor `bit_tick_o` pulses until a divisor byte is written.
- R2: With a divisor N >= 2, `tick16_o` is high for exactly one cycle in every N cycles.
- R3: With a divisor of 1, `tick16_o` is high on every cycle.
- R4: The divisor equals 256 * (upper byte) + (lower byte). A write updates only the byte that was strobed, and the other byte keeps its value.
- R5: A write to either byte that is sampled at clock edge E restarts the count. The first pulse is high in the cycle after edge E+(N-1), and later pulses follow every N cycles.
- R6: While the divisor is zero, `tick16_o` and `bit_tick_o` stay low.
- R7: With `mon_en` high, `bit_tick_o` pulses together with every 16th tick counted from the latest divisor write, and on no other cycle.
- R8: With `mon_en` low, `bit_tick_o` stays low while ticks continue.
- R9: The largest divisor, 65535, works: the first pulse comes 65534 edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_hi_we | input | 1 | Write strobe for the upper divisor byte |
| div_lo_we | input | 1 | Write strobe for the lower divisor byte |
| div_wdata | input | 8 | Byte value written by either strobe |
| mon_en | input | 1 | Enables the bit-rate monitor output |
| tick16_o | output | 1 | One-cycle pulse at 16x the bit rate |
| bit_tick_o | output | 1 | One-cycle pulse at the bit rate, gated by mon_en |

## Verification
A write is sampled on a rising edge. With divisor N, the first tick is due N-1 edges after that edge, and then every N edges. With a divisor of 1 the tick is already high in the cycle right after the write. The bench drives the strobes and samples the outputs on falling edges. After each write it counts falling edges until the tick appears and compares that count with N-1, then compares the gaps between later ticks with N. The bit-rate pulse is checked by counting ticks from the write and checking that the pulse is high on the 16th tick and low on every other cycle.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DIV_W  = BYTE_W * LANES;

  typedef logic [DIV_W-1:0] div_t;

  // next value of the down-counter when no reload happens
  function automatic div_t cnt_step(input div_t cnt, input div_t div);
    if (div == '0)        cnt_step = '0;
    else if (cnt <= 1)    cnt_step = div;
    else                  cnt_step = cnt - 1'b1;
  endfunction

  // tick condition from the registered count
  function automatic logic tick_due(input div_t cnt, input div_t div);
    tick_due = (div != '0) && (cnt == div_t'(1));
  endfunction
endpackage

// File: rtl/baudgen_divreg.sv
module baudgen_divreg
  import baudgen_pkg::*;
#(
  parameter int LW = BYTE_W,
  parameter int NL = LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   we,
  input  logic [LW-1:0]   wdata,
  output logic [LW*NL-1:0] div_q,
  output logic [LW*NL-1:0] div_next,
  output logic            load
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)     byte_q <= '0;
      else if (we[g]) byte_q <= wdata;
    end
    assign div_q[g*LW +: LW]    = byte_q;
    assign div_next[g*LW +: LW] = we[g] ? wdata : byte_q;
  end
  assign load = |we;
endmodule

// File: rtl/baudgen_downcnt.sv
module baudgen_downcnt
  import baudgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  div_t div_next,
  input  div_t div_q,
  output div_t cnt_q,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= div_next;
    else           cnt_q <= cnt_step(cnt_q, div_q);
  end
  assign tick = tick_due(cnt_q, div_q);
endmodule

// File: rtl/baudgen_phase.sv
module baudgen_phase #(
  parameter int OS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  input  logic mon_en,
  output logic bit_tick
);
  localparam int PW = (OS > 1) ? $clog2(OS) : 1;
  localparam logic [PW-1:0] LAST = PW'(OS - 1);
  logic [PW-1:0] ph_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    ph_q <= '0;
    else if (load) ph_q <= '0;
    else if (tick) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end
  assign bit_tick = mon_en && tick && (ph_q == LAST);
endmodule

// File: rtl/baudgen.sv
module baudgen
  import baudgen_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_hi_we,
  input  logic              div_lo_we,
  input  logic [BYTE_W-1:0] div_wdata,
  input  logic              mon_en,
  output logic              tick16_o,
  output logic              bit_tick_o
);
  div_t div_q, div_next, cnt_q;
  logic load_evt;
  logic tick_evt;

  baudgen_divreg u_divreg (
    .clk(clk), .rst_n(rst_n), .we({div_hi_we, div_lo_we}), .wdata(div_wdata),
    .div_q(div_q), .div_next(div_next), .load(load_evt)
  );

  baudgen_downcnt u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .div_next(div_next),
    .div_q(div_q), .cnt_q(cnt_q), .tick(tick_evt)
  );

  baudgen_phase #(.OS(OVERSAMPLE)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .tick(tick_evt),
    .mon_en(mon_en), .bit_tick(bit_tick_o)
  );

  assign tick16_o = tick_evt;
endmodule

// File: rtl/baudgen_checker.sv
module baudgen_checker
  import baudgen_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic tick16_o,
  input logic bit_tick_o,
  input logic load_evt,
  input div_t div_q,
  input div_t div_next,
  input div_t cnt_q
);
  a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !tick16_o && !bit_tick_o);
  a_r3_div1_every: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == div_t'(1)) |-> tick16_o);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16_o && div_q > div_t'(1) && !load_evt) |=> !tick16_o);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt_q == $past(div_next)) && (div_q == $past(div_next)));
  a_r7_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> tick16_o);
  a_r8_mon_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> !bit_tick_o);
endmodule

bind baudgen baudgen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .tick16_o(tick16_o),
  .bit_tick_o(bit_tick_o), .load_evt(load_evt), .div_q(div_q),
  .div_next(div_next), .cnt_q(cnt_q)
);

// File: tb/baudgen_bench.sv
`timescale 1ns/1ps
module baudgen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_hi_we = 1'b0, div_lo_we = 1'b0, mon_en = 1'b0;
  logic [7:0] div_wdata = '0;
  logic tick16_o, bit_tick_o;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  baudgen u_baudgen (
    .clk(clk), .rst_n(rst_n), .div_hi_we(div_hi_we), .div_lo_we(div_lo_we),
    .div_wdata(div_wdata), .mon_en(mon_en), .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit hi, input bit lo, input logic [7:0] d);
    @(negedge clk);
    div_hi_we = hi; div_lo_we = lo; div_wdata = d;
    @(negedge clk);
    div_hi_we = 1'b0; div_lo_we = 1'b0;
  endtask

  task automatic wait_tick(input int limit, output int k);
    k = 0;
    while (!tick16_o && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  // gap to next tick, starting on a tick cycle
  task automatic next_gap(input int limit, output int k, output int width);
    width = 0;
    k = 0;
    while (tick16_o && k < limit) begin @(negedge clk); k++; width++; end
    while (!tick16_o && k < limit) begin @(negedge clk); k++; end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick16_o || bit_tick_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    quiet(60, "R1 no pulses after reset");
  endtask

  task automatic t_zero();
    wr(1, 1, 8'h00);
    quiet(100, "R6 zero divisor idle");
  endtask

  task automatic t_div1();
    int hits = 0;
    mon_en = 1'b0;
    wr(0, 1, 8'd1);
    for (int i = 0; i < 40; i++) begin
      if (tick16_o) hits++;
      @(negedge clk);
    end
    chk(hits == 40, "R3 tick every cycle", hits, 40);
  endtask

  task automatic t_period(input logic [7:0] hi, input logic [7:0] lo_new, input string req);
    int k, w, n;
    n = {hi, lo_new};
    wr(0, 1, lo_new);
    wait_tick(70000, k);
    chk(k == n - 1, req, k, n - 1);
    for (int r = 0; r < 3; r++) begin
      next_gap(70000, k, w);
      chk(k == n, {req, " period"}, k, n);
      chk(w == 1, "R2 pulse width", w, 1);
    end
  endtask

  task automatic t_compose();
    int k, w;
    wr(0, 1, 8'd5);
    wr(1, 0, 8'd1);              // divisor 0x0105 = 261
    wait_tick(1000, k);
    chk(k == 260, "R4 upper byte write keeps lower", k, 260);
    wr(0, 1, 8'd2);              // divisor 0x0102 = 258
    wait_tick(1000, k);
    chk(k == 257, "R4 lower byte write keeps upper", k, 257);
    next_gap(1000, k, w);
    chk(k == 258, "R4 combined period", k, 258);
    wr(1, 0, 8'd0);
  endtask

  task automatic t_restart();
    int k;
    wr(0, 1, 8'd100);
    repeat (40) @(negedge clk);
    wr(0, 1, 8'd10);
    wait_tick(200, k);
    chk(k == 9, "R5 mid-count rewrite restarts", k, 9);
  endtask

  task automatic t_mon(input bit en);
    int ticks = 0, bad = 0, hit = 0;
    mon_en = en;
    wr(0, 1, 8'd2);
    for (int i = 0; i < 80; i++) begin
      if (tick16_o) begin
        ticks++;
        if (bit_tick_o) begin
          if (ticks % 16 == 0 && en) hit++;
          else bad++;
        end
      end else if (bit_tick_o) bad++;
      @(negedge clk);
    end
    if (en) begin
      chk(hit == 2, "R7 bit pulse on each 16th tick", hit, 2);
      chk(bad == 0, "R7 no stray bit pulse", bad, 0);
    end else begin
      chk(ticks >= 39, "R8 ticks continue", ticks, 40);
      chk(bad == 0, "R8 bit output held low", bad, 0);
    end
  endtask

  task automatic t_max();
    int k;
    mon_en = 1'b0;
    wr(0, 1, 8'hFF);
    wr(1, 0, 8'hFF);
    wait_tick(70000, k);
    chk(k == 65534, "R9 max divisor first tick", k, 65534);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero();
    t_div1();
    t_period(8'd0, 8'd5, "R2 divisor 5");
    t_period(8'd0, 8'd7, "R5 first tick divisor 7");
    t_compose();
    t_restart();
    t_mon(1'b1);
    t_mon(1'b0);
    t_max();
    wr(1, 1, 8'h00);
    quiet(300, "R6 stop after zero write");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule